// File: doc/BRIEF.md
# Digital Event Status and Rule Logic

This block gathers the discrete event lines of a board-management controller: four general-purpose inputs, two voltage-regulator over-temperature inputs, two termination-sense inputs and one internal over-temperature flag. Every line is brought into the clock domain by a two-flop synchronizer. A rising edge on a line latches a sticky status bit. Software clears a status bit by writing a 1 to it. Any status bit whose mask bit is clear pulls the active-low `alert_n` output low.

Each regulator over-temperature input can be enabled to drive a full-speed fan request while it is high. Two latched event outputs run without software help. A small rule field belonging to each output names the general inputs that act on it, and whether each of those inputs sets or resets the output. Once set, an output holds until a reset rule fires or software clears it.

Software sees the block through a simple register port. Writes are synchronous and strobed by `reg_we`. Reads are combinational from `reg_addr`.

Top module: `evt_status_rules`

## Requirements
- R1: Each input line passes through two synchronizing flops and an edge detector. A line that goes high before clock edge m sets its status bit at edge m+2. A line held high sets its bit only once.
- R2: Status bits are cleared by writing 1 to them. Writing 0 leaves a bit unchanged. If a new edge arrives in the same cycle as a clear, the bit stays set.
- R3: Address 1 holds the general-input status, with bit i for input i (bits 3:0). Address 4 holds the matching mask bits.
- R4: Address 2 holds the thermal status: bit 0 is regulator input 0, bit 1 is regulator input 1 and bit 2 is the internal over-temperature flag. Address 5 holds the matching mask bits.
- R5: Address 3 holds the termination status: bit 4 is termination input 0 and bit 5 is termination input 1. Address 6 holds the matching mask bits in the same positions.
- R6: `alert_n` is a registered output. It goes low one cycle after any status bit is set while its mask bit is 0. It stays high when every set bit is masked.
- R7: At address 0, bit 3 enables fan boost for regulator input 0 and bit 4 enables it for regulator input 1. `fan_full` is high while an enabled regulator input is high after synchronization, which is two edges after the pin.
- R8: Addresses 7 and 8 hold the rules for event outputs 0 and 1. In each, bit i enables general input i and bit 4+i selects its action: 1 sets the output, 0 resets it. A rule acts on the rising edge of its input, and the output changes at the same edge as the status bit.
- R9: When a set rule and a reset rule fire on the same output in the same cycle, the output is set.
- R10: An event output holds its value until a reset rule fires or software writes 1 to its bit at address 9. Reading address 9 returns the outputs in bits 1:0. A set rule beats a software clear in the same cycle.
- R11: After reset, every register reads 0, `alert_n` is 1, `fan_full` is 0 and both event outputs are 0.
- R12: Addresses 10 to 15 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_in | input | 4 | General-purpose event inputs, active high |
| vr_hot_in | input | 2 | Regulator over-temperature inputs, active high |
| term_in | input | 2 | Termination-sense inputs, active high |
| otemp_in | input | 1 | Internal over-temperature flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| alert_n | output | 1 | Interrupt output, active low |
| fan_full | output | 1 | Full-speed fan request |
| edo_out | output | 2 | Latched event-driven outputs |

## Verification
The assertions check these rules on every cycle:
- `fan_full` never rises without a regulator input two cycles earlier.
- `alert_n` is released only by a register write.
- An event output changes only after an edge on a general input or, for clears, a write.
- Unmapped addresses read zero.

Only the bench scenarios can show the rest:
- the exact bit positions in each status register;
- masking that keeps `alert_n` high;
- set beating reset, and set beating a software clear, when they collide;
- an output holding after its input falls.

The bench shows these by comparing outputs and read data against a behavioural model on every clock.

// File: rtl/evt_pkg.sv
// Package: shared register map and field positions for the event status block.
// Assumes an 8-bit data path and a 4-bit register address.
package evt_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    // Field positions that software decodes
    localparam int BOOST_LSB = 3;
    localparam int TERM_LSB  = 4;

    typedef enum logic [AW-1:0] {
        A_CFG   = 4'd0,
        A_GSTAT = 4'd1,
        A_TSTAT = 4'd2,
        A_DSTAT = 4'd3,
        A_GMASK = 4'd4,
        A_TMASK = 4'd5,
        A_DMASK = 4'd6,
        A_RULE0 = 4'd7,
        A_RULE1 = 4'd8,
        A_EDO   = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/evt_sync.sv
// Module: multi-bit level synchronizer.
// Each bit is independent. The output is the input delayed by STAGES clocks.
// Assumes the inputs are slow levels, so no gray coding is needed.
module evt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/evt_status.sv
// Module: sticky status bank, cleared by writing 1.
// A set pulse beats a clear of the same bit in the same cycle.
module evt_status #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat
);
    logic [W-1:0] clr_eff;

    // Apply the clear only when this bank is addressed
    always_comb clr_eff = clr_we ? clr_vec : '0;

    // Latch new events, drop the cleared bits
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_eff) | set_vec;
    end
endmodule

// File: rtl/evt_rule_out.sv
// Module: one latched event output driven by per-input rules.
// rule_en picks the inputs that act on the output. rule_set picks the action
// of each: 1 sets, 0 resets. Priority is set, then reset or software clear.
module evt_rule_out #(
    parameter int NG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] rise,
    input  logic [NG-1:0] rule_en,
    input  logic [NG-1:0] rule_set,
    input  logic          sw_clr,
    output logic          q
);
    logic set_hit, rst_hit;

    // Collect which enabled edges ask for set and which for reset
    always_comb begin
        set_hit = |(rise & rule_en & rule_set);
        rst_hit = |(rise & rule_en & ~rule_set);
    end

    // Latch the output with set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= 1'b0;
        else if (set_hit)            q <= 1'b1;
        else if (rst_hit || sw_clr)  q <= 1'b0;
    end
endmodule

// File: rtl/evt_status_rules.sv
// Module: top of the digital event status and rule logic.
// It synchronizes all event lines and detects their rising edges. It keeps the
// sticky status banks and masks, drives the registered alert, the fan boost
// request and the rule-driven latched outputs, and serves the register port.
// Assumes 2*NUM_GPIO <= DW and the field layout fixed in evt_pkg.
module evt_status_rules
    import evt_pkg::*;
#(
    parameter int NUM_GPIO    = 4,
    parameter int NUM_VR      = 2,
    parameter int NUM_TERM    = 2,
    parameter int NUM_EDO     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic [NUM_VR-1:0]   vr_hot_in,
    input  logic [NUM_TERM-1:0] term_in,
    input  logic                otemp_in,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                alert_n,
    output logic                fan_full,
    output logic [NUM_EDO-1:0]  edo_out
);
    localparam int NSRC    = NUM_GPIO + NUM_VR + NUM_TERM + 1;
    localparam int NTH     = NUM_VR + 1;
    localparam int VR_OFS  = NUM_GPIO;
    localparam int TRM_OFS = NUM_GPIO + NUM_VR;
    localparam int RULE_W  = 2 * NUM_GPIO;

    logic [NSRC-1:0]     src_lvl, src_prev, src_rise;
    logic [NUM_GPIO-1:0] g_rise, gst, gmask;
    logic [NTH-1:0]      th_rise, tst, tmask;
    logic [NUM_TERM-1:0] d_rise, dst, dmask;
    logic [NUM_VR-1:0]   vr_lvl, boost_en;
    logic [RULE_W-1:0]   rules [NUM_EDO];
    logic                any_event;

    evt_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({otemp_in, term_in, vr_hot_in, gpio_in}),
        .lvl  (src_lvl)
    );

    // Hold the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_lvl;
    end

    // Split the edge vector into its source groups
    always_comb begin
        src_rise = src_lvl & ~src_prev;
        g_rise   = src_rise[NUM_GPIO-1:0];
        th_rise  = {src_rise[NSRC-1], src_rise[VR_OFS +: NUM_VR]};
        d_rise   = src_rise[TRM_OFS +: NUM_TERM];
        vr_lvl   = src_lvl[VR_OFS +: NUM_VR];
    end

    evt_status #(.W(NUM_GPIO)) u_gstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(g_rise),
        .clr_we (reg_we && reg_addr == A_GSTAT),
        .clr_vec(reg_wdata[NUM_GPIO-1:0]),
        .stat   (gst)
    );

    evt_status #(.W(NTH)) u_tstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(th_rise),
        .clr_we (reg_we && reg_addr == A_TSTAT),
        .clr_vec(reg_wdata[NTH-1:0]),
        .stat   (tst)
    );

    evt_status #(.W(NUM_TERM)) u_dstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(d_rise),
        .clr_we (reg_we && reg_addr == A_DSTAT),
        .clr_vec(reg_wdata[TERM_LSB +: NUM_TERM]),
        .stat   (dst)
    );

    // Configuration, mask and rule registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_en <= '0;
            gmask    <= '0;
            tmask    <= '0;
            dmask    <= '0;
            for (int o = 0; o < NUM_EDO; o++) rules[o] <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_CFG)   boost_en <= reg_wdata[BOOST_LSB +: NUM_VR];
            if (reg_addr == A_GMASK) gmask    <= reg_wdata[NUM_GPIO-1:0];
            if (reg_addr == A_TMASK) tmask    <= reg_wdata[NTH-1:0];
            if (reg_addr == A_DMASK) dmask    <= reg_wdata[TERM_LSB +: NUM_TERM];
            for (int o = 0; o < NUM_EDO; o++)
                if (reg_addr == AW'(int'(A_RULE0) + o)) rules[o] <= reg_wdata[RULE_W-1:0];
        end
    end

    // One latched output per rule field
    for (genvar o = 0; o < NUM_EDO; o++) begin : g_edo
        evt_rule_out #(.NG(NUM_GPIO)) u_rule (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (g_rise),
            .rule_en (rules[o][NUM_GPIO-1:0]),
            .rule_set(rules[o][RULE_W-1:NUM_GPIO]),
            .sw_clr  (reg_we && reg_addr == A_EDO && reg_wdata[o]),
            .q       (edo_out[o])
        );
    end

    // Any unmasked pending event
    always_comb any_event = |(gst & ~gmask) | |(tst & ~tmask) | |(dst & ~dmask);

    // Register the alert so it is free of glitches
    always_ff @(posedge clk) begin
        if (!rst_n) alert_n <= 1'b1;
        else        alert_n <= ~any_event;
    end

    // Boost the fan while an enabled regulator input is high
    always_comb fan_full = |(vr_lvl & boost_en);

    // Read mux, with zero for unmapped addresses
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:   reg_rdata[BOOST_LSB +: NUM_VR]  = boost_en;
            A_GSTAT: reg_rdata[NUM_GPIO-1:0]         = gst;
            A_TSTAT: reg_rdata[NTH-1:0]              = tst;
            A_DSTAT: reg_rdata[TERM_LSB +: NUM_TERM] = dst;
            A_GMASK: reg_rdata[NUM_GPIO-1:0]         = gmask;
            A_TMASK: reg_rdata[NTH-1:0]              = tmask;
            A_DMASK: reg_rdata[TERM_LSB +: NUM_TERM] = dmask;
            A_RULE0: reg_rdata[RULE_W-1:0]           = rules[0];
            A_RULE1: reg_rdata[RULE_W-1:0]           = rules[1];
            A_EDO:   reg_rdata[NUM_EDO-1:0]          = edo_out;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_status_rules_chk.sv
// Module: temporal checks on the ports of evt_status_rules, attached by bind.
// Assumes the default widths and a two-stage synchronizer.
module evt_status_rules_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] gpio_in,
    input logic [1:0] vr_hot_in,
    input logic       reg_we,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       alert_n,
    input logic       fan_full,
    input logic [1:0] edo_out
);
    // R11: outputs idle in the first cycle after reset
    p_reset_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (alert_n && !fan_full && edo_out == 2'b00));

    // R7: fan request needs a regulator input two cycles earlier
    p_fan_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fan_full |-> (|$past(vr_hot_in, 2)));

    // R6: alert is released only by a register write
    p_alert_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_n) |-> $past(reg_we, 2));

    // R8: an event output rises only after a general-input edge
    p_edo_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edo_out & ~$past(edo_out))) |->
        (|($past(gpio_in, 3) & ~$past(gpio_in, 4))));

    // R10: an event output falls only on a write or a general-input edge
    p_edo_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(edo_out) & ~edo_out)) |->
        ($past(reg_we) || (|($past(gpio_in, 3) & ~$past(gpio_in, 4)))));

    // R12: unmapped addresses read zero
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 4'd9) |-> (reg_rdata == 8'h00));
endmodule

bind evt_status_rules evt_status_rules_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gpio_in  (gpio_in),
    .vr_hot_in(vr_hot_in),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .alert_n  (alert_n),
    .fan_full (fan_full),
    .edo_out  (edo_out)
);

// File: tb/sim_evt_status_rules.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus scenarios.
module sim_evt_status_rules;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] gpio_in = '0;
    logic [1:0] vr_hot_in = '0;
    logic [1:0] term_in = '0;
    logic       otemp_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alert_n, fan_full;
    logic [1:0] edo_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_status_rules u0 (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .vr_hot_in(vr_hot_in),
        .term_in(term_in), .otemp_in(otemp_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alert_n(alert_n), .fan_full(fan_full), .edo_out(edo_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [8:0]   hist[$] = '{9'd0, 9'd0, 9'd0};
    logic [7:0] m_cfg, m_gs, m_ts, m_ds, m_gm, m_tm, m_dm, m_r0, m_r1;
    logic [1:0] m_edo;
    logic       m_alert_n;

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cfg;
            4'd1: return m_gs;
            4'd2: return m_ts;
            4'd3: return m_ds;
            4'd4: return m_gm;
            4'd5: return m_tm;
            4'd6: return m_dm;
            4'd7: return m_r0;
            4'd8: return m_r1;
            4'd9: return {6'd0, m_edo};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic rule_next(input logic [7:0] r, input bit [3:0] rs,
                                       input logic cur, input logic swc);
        bit s = 0, c = 0;
        for (int g = 0; g < 4; g++)
            if (rs[g] && r[g]) begin
                if (r[4+g]) s = 1; else c = 1;
            end
        if (s) return 1'b1;
        if (c || swc) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        bit [8:0] cur, rs;
        logic we; logic [3:0] a; logic [7:0] d; logic fexp;
        cur = {otemp_in, term_in, vr_hot_in, gpio_in};
        we = reg_we; a = reg_addr; d = reg_wdata;
        if (!rst_n) begin
            {m_cfg, m_gs, m_ts, m_ds, m_gm, m_tm, m_dm, m_r0, m_r1} = '0;
            m_edo = 2'b00; m_alert_n = 1'b1;
            hist = '{9'd0, 9'd0, 9'd0};
        end else begin
            rs = hist[1] & ~hist[2];
            m_alert_n = ~(|(m_gs & ~m_gm) | |(m_ts & ~m_tm) | |(m_ds & ~m_dm));
            m_edo[0] = rule_next(m_r0, rs[3:0], m_edo[0], we && a == 4'd9 && d[0]);
            m_edo[1] = rule_next(m_r1, rs[3:0], m_edo[1], we && a == 4'd9 && d[1]);
            m_gs = (m_gs & ~((we && a == 4'd1) ? (d & 8'h0f) : 8'h00)) | {4'd0, rs[3:0]};
            m_ts = (m_ts & ~((we && a == 4'd2) ? (d & 8'h07) : 8'h00)) | {5'd0, rs[8], rs[5], rs[4]};
            m_ds = (m_ds & ~((we && a == 4'd3) ? (d & 8'h30) : 8'h00)) | {2'd0, rs[7:6], 4'd0};
            if (we) begin
                case (a)
                    4'd0: m_cfg = d & 8'h18;
                    4'd4: m_gm  = d & 8'h0f;
                    4'd5: m_tm  = d & 8'h07;
                    4'd6: m_dm  = d & 8'h30;
                    4'd7: m_r0  = d;
                    4'd8: m_r1  = d;
                    default: ;
                endcase
            end
            hist.push_front(cur);
            void'(hist.pop_back());
        end
        #3;
        fexp = (hist[1][4] & m_cfg[3]) | (hist[1][5] & m_cfg[4]);
        check("R6 alert_n per clock", {7'd0, alert_n}, {7'd0, m_alert_n});
        check("R7 fan_full per clock", {7'd0, fan_full}, {7'd0, fexp});
        check("R10 edo_out per clock", {6'd0, edo_out}, {6'd0, m_edo});
        check("R3 reg_rdata per clock", reg_rdata, m_read(reg_addr));
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #2;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_gpio(input logic [3:0] m);
        @(negedge clk); gpio_in = gpio_in | m;
        @(negedge clk); gpio_in = gpio_in & ~m;
        tick(5);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R11: reset state
        check("R11 alert_n after reset", {7'd0, alert_n}, 8'h01);
        check("R11 edo after reset", {6'd0, edo_out}, 8'h00);
        for (int a = 0; a < 10; a++) rd(4'(a), 8'h00, "R11 register reset value");

        // R1, R3: gpio0 edge latches bit 0; held level latches once
        @(negedge clk); gpio_in[0] = 1'b1;
        tick(2); #2;
        check("R1 status not yet set", {7'd0, alert_n}, 8'h01);
        tick(4);
        rd(4'd1, 8'h01, "R3 gpio0 status bit");
        check("R6 alert low on unmasked event", {7'd0, alert_n}, 8'h00);
        // R2: clear while level still high; no new edge so bit stays clear
        wr(4'd1, 8'h01);
        tick(3);
        rd(4'd1, 8'h00, "R1 held level sets once / R2 clear");
        check("R6 alert released", {7'd0, alert_n}, 8'h01);
        @(negedge clk); gpio_in[0] = 1'b0;
        tick(4);

        // R6, R3: masked gpio1 keeps alert high
        wr(4'd4, 8'h02);
        pulse_gpio(4'b0010);
        rd(4'd1, 8'h02, "R3 gpio1 status with mask");
        check("R6 masked event keeps alert high", {7'd0, alert_n}, 8'h01);
        wr(4'd1, 8'h00);
        rd(4'd1, 8'h02, "R2 writing 0 keeps bit");
        wr(4'd1, 8'h02);

        // R2: edge and clear in the same cycle, set wins
        @(negedge clk); gpio_in[3] = 1'b1;
        tick(2);
        reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h08;
        @(negedge clk); reg_we = 1'b0;
        rd(4'd1, 8'h08, "R2 set beats clear");
        @(negedge clk); gpio_in[3] = 1'b0;
        wr(4'd1, 8'h08);

        // R7, R4: fan boost for regulator 0 only
        wr(4'd0, 8'h08);
        @(negedge clk); vr_hot_in = 2'b01;
        tick(1); #2;
        check("R7 fan not before sync", {7'd0, fan_full}, 8'h00);
        tick(2); #2;
        check("R7 fan boost regulator 0", {7'd0, fan_full}, 8'h01);
        @(negedge clk); vr_hot_in = 2'b10;
        tick(4); #2;
        check("R7 regulator 1 not enabled", {7'd0, fan_full}, 8'h00);
        @(negedge clk); vr_hot_in = 2'b00; otemp_in = 1'b1;
        tick(5);
        rd(4'd2, 8'h07, "R4 thermal status bits");
        wr(4'd5, 8'h07);
        wr(4'd2, 8'h07);
        otemp_in = 1'b0;

        // R5: termination input 1 maps to bit 5
        @(negedge clk); term_in = 2'b10;
        tick(5);
        rd(4'd3, 8'h20, "R5 termination status bit 5");
        wr(4'd6, 8'h30);
        rd(4'd6, 8'h30, "R5 termination mask bits");
        term_in = 2'b00;
        wr(4'd3, 8'h30);
        wr(4'd4, 8'h0f);

        // R8, R10: gpio2 sets edo0, gpio3 resets it
        wr(4'd7, 8'h4c);
        pulse_gpio(4'b0100);
        check("R8 set rule drives edo0", {6'd0, edo_out}, 8'h01);
        tick(5);
        rd(4'd9, 8'h01, "R10 edo0 holds after input falls");
        pulse_gpio(4'b1000);
        check("R8 reset rule clears edo0", {6'd0, edo_out}, 8'h00);

        // R9: set and reset rules on edo1 in the same cycle
        wr(4'd8, 8'h13);
        pulse_gpio(4'b0011);
        check("R9 set beats reset", {6'd0, edo_out}, 8'h02);

        // R10: software clear of edo1
        wr(4'd9, 8'h02);
        rd(4'd9, 8'h00, "R10 software clear");

        // R12: unmapped address
        wr(4'd12, 8'hff);
        rd(4'd12, 8'h00, "R12 unmapped reads zero");
        rd(4'd7, 8'h4c, "R12 write elsewhere no effect");

        tick(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule